// File: doc/BRIEF.md
# Deferred Bus Access Unit

This unit holds one outstanding external byte access (a read or a write) and lets it finish in the background while the surrounding core keeps advancing time. The core opens an access by giving an address, a direction and a latency in clocks. After that the core reports its progress with step strobes, and each strobe carries the number of clocks the core has just spent. The unit subtracts that number from the remaining latency. Once the remaining latency fits inside a single step, the access fires on the external bus.

A single shared memory data register sits at the centre of the unit. When a read completes, the returned byte is captured into this register. When a write completes, the byte driven out is the register's current contents. The core can also load the register directly, so that it can stage data before a write. A busy flag combines the unit's own nonzero remaining latency with two activity inputs that come from neighbouring fetch and copy engines.

Top module: `bus_defer_unit`

## Requirements
- R1: After reset, pending_o, err_o, bus_rd_o, bus_wr_o and mdr_o are all zero, bus_addr_o is zero, and busy_o follows only fill_active_i and dma_active_i.
- R2: When start_i is high and no access is pending, pending_o is high from the next cycle. bus_addr_o then shows start_addr_i, and the direction (start_write_i: 1 is a write, 0 is a read) and the latency start_lat_i are stored.
- R3: A step strobe (step_i, with step_clks_i as N in 1..255) while pending with remaining latency greater than N reduces the remaining latency by N. The access stays pending and no bus strobe is driven.
- R4: A step strobe while pending with remaining latency less than or equal to N completes the access. In that same cycle exactly one of bus_rd_o or bus_wr_o is high, as the stored direction selects. From the next cycle pending_o is low and the remaining latency is zero.
- R5: On a read completion, mdr_o takes the value of bus_rdata_i sampled in the completion cycle.
- R6: On a write completion, bus_wdata_o equals the current mdr_o and bus_addr_o equals the stored address. The write itself does not change mdr_o.
- R7: start_i while an access is pending is ignored, so the address, direction and latency are unchanged. err_o is high for exactly the following cycle.
- R8: busy_o is high exactly when fill_active_i is high, or dma_active_i is high, or the remaining latency is nonzero. A pending access with zero latency does not raise busy_o.
- R9: mdr_wr_i loads mdr_wdata_i into mdr_o on the next cycle, unless a read completes in the same cycle, in which case the read data wins.
- R10: A step strobe while nothing is pending has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Open a new access |
| start_write_i | input | 1 | Direction of new access, 1 = write |
| start_addr_i | input | AW | Address of new access |
| start_lat_i | input | LW | Latency of new access in clocks |
| step_i | input | 1 | Core advanced by step_clks_i clocks |
| step_clks_i | input | SW | Clocks in this step |
| mdr_wr_i | input | 1 | Load memory data register |
| mdr_wdata_i | input | DW | Value for memory data register |
| fill_active_i | input | 1 | Neighbouring fetch engine active |
| dma_active_i | input | 1 | Neighbouring copy engine active |
| bus_rdata_i | input | DW | External read data |
| bus_rd_o | output | 1 | External read strobe |
| bus_wr_o | output | 1 | External write strobe |
| bus_addr_o | output | AW | External address |
| bus_wdata_o | output | DW | External write data |
| mdr_o | output | DW | Memory data register |
| pending_o | output | 1 | Access outstanding |
| busy_o | output | 1 | Combined activity flag |
| err_o | output | 1 | Rejected start, one-cycle pulse |

## Verification
The hardest situation to reach is a step whose size exactly equals the remaining latency, because it lies on the boundary between R3 and R4. The companion case, one clock more, is just as hard. Random stimulus rarely lands on either value, so directed sequences open accesses with latencies of N, N+1 and zero and then step by N. Further directed cycles collide a read completion with a register load and with a rejected start. A long constrained-random run then mixes in small latencies and small step sizes, so that multi-step countdowns and completions happen often.

// File: rtl/bus_defer_unit.sv
module bus_defer_unit #(
  parameter int AW = 24,
  parameter int DW = 8,
  parameter int LW = 16,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          start_write_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [LW-1:0] start_lat_i,
  input  logic          step_i,
  input  logic [SW-1:0] step_clks_i,
  input  logic          mdr_wr_i,
  input  logic [DW-1:0] mdr_wdata_i,
  input  logic          fill_active_i,
  input  logic          dma_active_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic [DW-1:0] mdr_o,
  output logic          pending_o,
  output logic          busy_o,
  output logic          err_o
);
  localparam int PADW = LW - SW;

  logic          pend_q, dir_q, err_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] cnt_q;
  logic [DW-1:0] mdr_q;
  logic [LW-1:0] step_ext;
  logic          finish;

  assign step_ext = {{PADW{1'b0}}, step_clks_i};
  assign finish   = pend_q & step_i & (cnt_q <= step_ext);

  assign bus_rd_o    = finish & ~dir_q;
  assign bus_wr_o    = finish &  dir_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = mdr_q;
  assign mdr_o       = mdr_q;
  assign pending_o   = pend_q;
  assign err_o       = err_q;
  assign busy_o      = fill_active_i | dma_active_i | (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dir_q  <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      err_q <= start_i & pend_q;
      if (!pend_q) begin
        if (start_i) begin
          pend_q <= 1'b1;
          dir_q  <= start_write_i;
          addr_q <= start_addr_i;
          cnt_q  <= start_lat_i;
        end
      end else if (step_i) begin
        if (finish) begin
          pend_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q - step_ext;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mdr_q <= '0;
    else if (bus_rd_o)
      mdr_q <= bus_rdata_i;
    else if (mdr_wr_i)
      mdr_q <= mdr_wdata_i;
  end
endmodule

// File: rtl/bus_defer_unit_chk.sv
module bus_defer_unit_chk #(
  parameter int AW = 24,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [AW-1:0] start_addr_i,
  input logic          step_i,
  input logic          mdr_wr_i,
  input logic          fill_active_i,
  input logic          dma_active_i,
  input logic [DW-1:0] bus_rdata_i,
  input logic          bus_rd_o,
  input logic          bus_wr_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] mdr_o,
  input logic          pending_o,
  input logic          busy_o,
  input logic          err_o
);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_o && start_i) |=> (pending_o && bus_addr_o == $past(start_addr_i)));

  p_strobe_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_o || bus_wr_o) |-> (pending_o && step_i && $onehot0({bus_rd_o, bus_wr_o})));

  p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_o || bus_wr_o) |=> !pending_o);

  p_read_mdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_o |=> (mdr_o == $past(bus_rdata_i)));

  p_write_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o && !mdr_wr_i) |=> $stable(mdr_o));

  p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && start_i) |=> (err_o && $stable(bus_addr_o)));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_active_i || dma_active_i) |-> busy_o);

  p_idle_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_o && !start_i) |=> (!pending_o && $stable(bus_addr_o)));
endmodule

bind bus_defer_unit bus_defer_unit_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
  .step_i(step_i), .mdr_wr_i(mdr_wr_i), .fill_active_i(fill_active_i),
  .dma_active_i(dma_active_i), .bus_rdata_i(bus_rdata_i), .bus_rd_o(bus_rd_o),
  .bus_wr_o(bus_wr_o), .bus_addr_o(bus_addr_o), .mdr_o(mdr_o),
  .pending_o(pending_o), .busy_o(busy_o), .err_o(err_o)
);

// File: tb/bus_defer_unit_tb_top.sv
module bus_defer_unit_tb_top;
  localparam int AW = 24, DW = 8, LW = 16, SW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, start_write_i = 0, step_i = 0, mdr_wr_i = 0;
  logic fill_active_i = 0, dma_active_i = 0;
  logic [AW-1:0] start_addr_i = '0;
  logic [LW-1:0] start_lat_i = '0;
  logic [SW-1:0] step_clks_i = '0;
  logic [DW-1:0] mdr_wdata_i = '0, bus_rdata_i = '0;
  logic bus_rd_o, bus_wr_o, pending_o, busy_o, err_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o, mdr_o;

  always #10 clk = ~clk;

  bus_defer_unit #(.AW(AW), .DW(DW), .LW(LW), .SW(SW)) dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  bit m_pend = 0, m_dir = 0, m_err = 0;
  int m_cnt = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_mdr = '0;

  function automatic bit exp_finish(bit pend, bit stp, int cnt, int n);
    return pend && stp && (cnt <= n);
  endfunction

  function automatic bit exp_busy(bit f, bit d, int cnt);
    return f || d || (cnt != 0);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_all(string req);
    bit fin;
    fin = exp_finish(m_pend, step_i, m_cnt, int'(step_clks_i));
    chk(bus_rd_o == (fin && !m_dir), {req, " R4 rd strobe"}, bus_rd_o, fin && !m_dir);
    chk(bus_wr_o == (fin && m_dir), {req, " R6 wr strobe"}, bus_wr_o, fin && m_dir);
    chk(bus_addr_o == m_addr, {req, " R2 addr"}, bus_addr_o, m_addr);
    chk(bus_wdata_o == m_mdr, {req, " R6 wdata"}, bus_wdata_o, m_mdr);
    chk(mdr_o == m_mdr, {req, " R5 mdr"}, mdr_o, m_mdr);
    chk(pending_o == m_pend, {req, " R3 pending"}, pending_o, m_pend);
    chk(err_o == m_err, {req, " R7 err"}, err_o, m_err);
    chk(busy_o == exp_busy(fill_active_i, dma_active_i, m_cnt), {req, " R8 busy"},
        busy_o, exp_busy(fill_active_i, dma_active_i, m_cnt));
  endtask

  task automatic cyc(bit st, bit wr, logic [AW-1:0] a, int lat, bit stp, int n,
                     bit mw, logic [DW-1:0] md, bit f, bit d, logic [DW-1:0] rd,
                     string req);
    bit fin;
    start_i = st; start_write_i = wr; start_addr_i = a; start_lat_i = LW'(lat);
    step_i = stp; step_clks_i = SW'(n); mdr_wr_i = mw; mdr_wdata_i = md;
    fill_active_i = f; dma_active_i = d; bus_rdata_i = rd;
    #2;
    cmp_all(req);
    fin = exp_finish(m_pend, stp, m_cnt, n);
    @(posedge clk);
    m_err = st && m_pend;
    if (fin && !m_dir) m_mdr = rd;
    else if (mw) m_mdr = md;
    if (!m_pend) begin
      if (st) begin m_pend = 1; m_dir = wr; m_addr = a; m_cnt = lat; end
    end else if (stp) begin
      if (fin) begin m_pend = 0; m_cnt = 0; end
      else m_cnt = m_cnt - n;
    end
    @(negedge clk);
  endtask

  task automatic idle(string req);
    cyc(0, 0, '0, 0, 0, 1, 0, '0, 0, 0, '0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    chk(pending_o == 0 && err_o == 0 && mdr_o == 0, "R1 reset regs", {pending_o, err_o, mdr_o}, 0);
    chk(bus_rd_o == 0 && bus_wr_o == 0 && bus_addr_o == 0, "R1 reset bus", {bus_rd_o, bus_wr_o}, 0);
    chk(busy_o == 0, "R1 reset busy", busy_o, 0);
    rst_n = 1;
    @(negedge clk);

    // R10: step while idle
    cyc(0, 0, '0, 0, 1, 5, 0, '0, 0, 0, 8'hAA, "R10 idle step");
    // R9: core load
    cyc(0, 0, '0, 0, 0, 1, 1, 8'h5C, 0, 0, '0, "R9 load");
    // R3/R4: exact boundary write
    cyc(1, 1, 24'h012345, 10, 0, 1, 0, '0, 0, 0, '0, "R2 start write");
    cyc(1, 0, 24'hFFFFFF, 3, 0, 1, 0, '0, 0, 0, '0, "R7 reject");
    idle("R7 err pulse");
    cyc(0, 0, '0, 0, 1, 4, 0, '0, 0, 0, '0, "R3 partial");
    cyc(0, 0, '0, 0, 1, 6, 0, '0, 0, 0, '0, "R4 exact write");
    idle("R6 after write");
    // N+1 latency read, colliding with core load and a start
    cyc(1, 0, 24'h00ABCD, 9, 0, 1, 0, '0, 0, 0, '0, "R2 start read");
    cyc(0, 0, '0, 0, 1, 8, 0, '0, 0, 0, '0, "R3 one left");
    cyc(1, 1, 24'h111111, 2, 1, 8, 1, 8'h77, 0, 0, 8'hE1, "R9 read wins");
    idle("R5 read data");
    // zero latency: pending but not busy
    cyc(1, 0, 24'h000042, 0, 0, 1, 0, '0, 1, 0, '0, "R8 zero lat");
    idle("R8 zero busy");
    cyc(0, 0, '0, 0, 1, 1, 0, '0, 0, 1, 8'h3D, "R4 zero done");
    idle("R5 zero read");

    for (int i = 0; i < 3000; i++) begin
      bit st, wr, stp, mw, f, d;
      int lat, n;
      st  = ($urandom % 4) == 0;
      wr  = $urandom % 2;
      stp = ($urandom % 2) == 0;
      mw  = ($urandom % 5) == 0;
      f   = ($urandom % 6) == 0;
      d   = ($urandom % 6) == 0;
      lat = ($urandom % 8 == 0) ? int'($urandom % 700) : int'($urandom % 20);
      n   = 1 + int'($urandom % (($urandom % 3 == 0) ? 255 : 8));
      cyc(st, wr, AW'($urandom), lat, stp, n, mw, DW'($urandom), f, d, DW'($urandom), "rand");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule